// File: doc/BRIEF.md
# Signed Sequential Multiplier (Magnitude and Sign Fix-up)

This block multiplies two signed operands of `W` bits each, held in two's-complement form. The result is a `2W`-bit product. A single-cycle `start` pulse captures both operands. The block then strips the sign from each operand and keeps its unsigned magnitude. It multiplies the two magnitudes by repeated shift-and-add, one multiplier bit per clock cycle, beginning at the least significant bit. When that is finished, it negates the unsigned result if exactly one operand was negative.

While the loop runs, `busy` is high, and any new `start` is ignored. A one-cycle `done` pulse marks the cycle in which `product` first shows the new result. `product` then keeps that value until the next accepted start completes. The product is full width, so no input pair can overflow it. The most negative input is handled correctly.

Top module: `smag_mult`

## Requirements
- R1: After reset, `busy`, `done` and `product` are all zero.
- R2: A `start` sampled high while `busy` is low makes `busy` go high on the next cycle. `busy` then stays high for exactly `W` cycles.
- R3: `done` is high for exactly one cycle, on the cycle right after the last `busy` cycle. During that cycle `busy` is low.
- R4: When both operands are non-negative, `product` equals their unsigned product. For example, 0111 times 0101 gives 00100011.
- R5: When both operands are negative (bit `W-1` set), `product` is the positive product of their magnitudes. For example, 1001 (-7) times 1011 (-5) gives 35.
- R6: When exactly one operand is negative, `product` is the two's-complement negative of the product of the magnitudes, so that its bit `2W-1` is 1.
- R7: An operand of 1 followed by `W-1` zeros is treated as magnitude 2^(W-1) with a negative sign. With `W`=4, -8 times -8 gives 64 and -8 times 7 gives -56.
- R8: When either operand is zero, `product` is all zeros, whatever the signs.
- R9: `product` changes only in the `done` cycle and holds its value otherwise. A `start` that arrives while `busy` is high changes neither the timing nor the result of the operation in progress.
- R10: For every pair of `W`-bit operands, `product` equals their exact signed product in `2W` bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiply; accepted only while idle |
| op_a | input | W | Multiplicand, two's complement |
| op_b | input | W | Multiplier, two's complement |
| busy | output | 1 | Shift-add loop in progress |
| done | output | 1 | One-cycle pulse: new product valid |
| product | output | 2W | Signed product, two's complement |

## Verification
A fault in the iteration counter shows up as a `busy` window that is not `W` cycles long. That is visible at the first `done`, roughly `W` cycles after the start. A wrong accumulator, a wrong shifted multiplicand, or a wrong captured sign bit gives a wrong `product` in that same `done` cycle. The operand classes (zero, most negative, mixed signs) expose sign faults that positive-only pairs would hide. A restart while busy, or a leak into the product register, shows as an extra or shifted `done` pulse, or as a product that changes while idle.

// File: rtl/smag_mult_pkg.sv
package smag_mult_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } state_e;
endpackage

// File: rtl/smag_mag.sv
// Splits a two's-complement value into sign and unsigned magnitude.
// The most negative value maps to magnitude 2^(W-1), which still fits in W bits.
module smag_mag #(
    parameter int W = 4
) (
    input  logic [W-1:0] val,
    output logic [W-1:0] mag,
    output logic         neg
);
    always_comb begin
        neg = val[W-1];
        mag = neg ? (~val + W'(1)) : val;
    end
endmodule

// File: rtl/smag_fixsign.sv
// Applies the result sign to an unsigned magnitude; zero stays zero.
module smag_fixsign #(
    parameter int PW = 8
) (
    input  logic [PW-1:0] mag,
    input  logic          flip,
    output logic [PW-1:0] res
);
    always_comb begin
        if (flip && (mag != '0)) begin
            res = ~mag + PW'(1);
        end else begin
            res = mag;
        end
    end
endmodule

// File: rtl/smag_ctrl.sv
// Sequencer: accepts start when idle, runs W steps, then pulses done.
module smag_ctrl
    import smag_mult_pkg::*;
#(
    parameter int W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic load,
    output logic step,
    output logic last,
    output logic done
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;

    typedef struct packed {
        state_e        state;
        logic [CW-1:0] cnt;
        logic          done;
    } ctrl_t;

    ctrl_t c_d, c_q;

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        load     = (c_q.state == ST_IDLE) && start;
        step     = (c_q.state == ST_RUN);
        last     = step && (c_q.cnt == CW'(W - 1));
        if (load) begin
            c_d.state = ST_RUN;
            c_d.cnt   = '0;
        end else if (step) begin
            c_d.cnt = c_q.cnt + CW'(1);
            if (last) begin
                c_d.state = ST_IDLE;
                c_d.done  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{state: ST_IDLE, cnt: '0, done: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign busy = (c_q.state == ST_RUN);
    assign done = c_q.done;
endmodule

// File: rtl/smag_mult.sv
// Signed multiplier: magnitudes, shift-add over multiplier bits LSB first,
// sign fixed on the final sum.
module smag_mult #(
    parameter int W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [W-1:0]   op_a,
    input  logic [W-1:0]   op_b,
    output logic           busy,
    output logic           done,
    output logic [2*W-1:0] product
);
    localparam int PW = 2 * W;

    typedef struct packed {
        logic [PW-1:0] mcand;
        logic [W-1:0]  mplier;
        logic [PW-1:0] acc;
        logic          flip;
        logic [PW-1:0] product;
    } dp_t;

    dp_t d_d, d_q;

    logic          load, step, last;
    logic [W-1:0]  mag_a, mag_b;
    logic          neg_a, neg_b;
    logic [PW-1:0] sum;
    logic [PW-1:0] signed_sum;

    smag_ctrl #(.W(W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .load  (load),
        .step  (step),
        .last  (last),
        .done  (done)
    );

    smag_mag #(.W(W)) u_mag_a (.val(op_a), .mag(mag_a), .neg(neg_a));
    smag_mag #(.W(W)) u_mag_b (.val(op_b), .mag(mag_b), .neg(neg_b));

    smag_fixsign #(.PW(PW)) u_fix (
        .mag  (sum),
        .flip (d_q.flip),
        .res  (signed_sum)
    );

    // Partial product is the shifted multiplicand or zero, picked by the current bit.
    assign sum = d_q.acc + (d_q.mplier[0] ? d_q.mcand : '0);

    always_comb begin
        d_d = d_q;
        if (load) begin
            d_d.mcand  = {{W{1'b0}}, mag_a};
            d_d.mplier = mag_b;
            d_d.acc    = '0;
            d_d.flip   = neg_a ^ neg_b;
        end else if (step) begin
            d_d.acc    = sum;
            d_d.mcand  = d_q.mcand << 1;
            d_d.mplier = d_q.mplier >> 1;
            if (last) begin
                d_d.product = signed_sum;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_q <= '0;
        end else begin
            d_q <= d_d;
        end
    end

    assign product = d_q.product;
endmodule

// File: rtl/smag_mult_chk.sv
module smag_mult_chk #(
    parameter int W = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic [W-1:0]   op_a,
    input logic [W-1:0]   op_b,
    input logic           busy,
    input logic           done,
    input logic [2*W-1:0] product
);
    logic [W-1:0] cap_a, cap_b;
    int           bcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_a <= '0;
            cap_b <= '0;
            bcnt  <= 0;
        end else if (start && !busy) begin
            cap_a <= op_a;
            cap_b <= op_b;
            bcnt  <= 0;
        end else if (busy) begin
            bcnt <= bcnt + 1;
        end
    end

    // R2
    a_r2_busy_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    // R2
    a_r2_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (bcnt == W));
    // R3
    a_r3_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R3
    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R6
    a_r6_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cap_a != '0 && cap_b != '0) |-> (product[2*W-1] == (cap_a[W-1] ^ cap_b[W-1])));
    // R8
    a_r8_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (cap_a == '0 || cap_b == '0)) |-> (product == '0));
    // R9
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(product));
endmodule

bind smag_mult smag_mult_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .op_a    (op_a),
    .op_b    (op_b),
    .busy    (busy),
    .done    (done),
    .product (product)
);

// File: tb/smag_mult_tb.sv
`timescale 1ns/1ps
module smag_mult_tb;
    localparam int W  = 4;
    localparam int PW = 2 * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [W-1:0]  op_a = '0;
    logic [W-1:0]  op_b = '0;
    logic          busy, done;
    logic [PW-1:0] product;

    int            n_tests = 0;
    int            n_fail  = 0;
    logic [PW-1:0] exp_q[$];
    string         tag_q[$];
    logic [PW-1:0] last_exp = '0;
    int            bcnt = 0;
    logic          done_prev = 1'b0;
    bit            finished = 1'b0;

    always #4 clk = ~clk;

    smag_mult #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
        .busy(busy), .done(done), .product(product)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [PW-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
        logic signed [PW-1:0] sa, sb, p;
        sa = {{W{a[W-1]}}, a};
        sb = {{W{b[W-1]}}, b};
        p  = sa * sb;
        return p;
    endfunction

    function automatic string classify(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] most_neg;
        most_neg = {1'b1, {(W-1){1'b0}}};
        if (a == '0 || b == '0) return "R8 zero product";
        if (a == most_neg || b == most_neg) return "R7 most negative";
        if (a[W-1] && b[W-1]) return "R5 both negative";
        if (a[W-1] ^ b[W-1]) return "R6 mixed signs";
        return "R4 positive";
    endfunction

    task automatic run(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
        @(negedge clk);
        while (busy) @(negedge clk);
        op_a  = a;
        op_b  = b;
        start = 1'b1;
        exp_q.push_back(ref_mul(a, b));
        tag_q.push_back(tag);
        last_exp = ref_mul(a, b);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy || exp_q.size() != 0) @(negedge clk);
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (busy) bcnt++;
            if (done) begin
                check(bcnt == W, "R2 busy length", bcnt, W);
                check(!busy, "R3 busy low at done", busy, 0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected done", product, 0);
                end else begin
                    automatic logic [PW-1:0] e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    check(product == e, {t, " / R10"}, product, e);
                end
                bcnt = 0;
            end
            if (done && done_prev) check(1'b0, "R3 done wider than one cycle", 1, 0);
            done_prev = done;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R1 busy after reset", busy, 0);
        check(done == 1'b0, "R1 done after reset", done, 0);
        check(product == '0, "R1 product after reset", product, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R1 idle after release", {busy, done}, 0);

        run(4'b0111, 4'b0101, "R4 7x5");
        check(busy == 1'b1, "R2 busy next cycle", busy, 1);
        wait_idle();
        run(4'b1001, 4'b1011, "R5 -7x-5");
        run(4'b1000, 4'b1000, "R7 -8x-8");
        run(4'b1000, 4'b0111, "R7 -8x7");
        run(4'b0000, 4'b1101, "R8 0x-3");
        run(4'b0011, 4'b1110, "R6 3x-2");
        wait_idle();

        // R9: hold while idle
        repeat (6) @(negedge clk);
        check(product == last_exp, "R9 product held", product, last_exp);

        // R9: start while busy ignored
        run(4'b0110, 4'b0011, "R9 ignored restart");
        @(negedge clk);
        op_a  = 4'b1111;
        op_b  = 4'b0111;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_idle();
        repeat (3) @(negedge clk);
        check(product == last_exp, "R9 product after ignored start", product, last_exp);

        // R10: every operand pair
        for (int a = 0; a < (1 << W); a++) begin
            for (int b = 0; b < (1 << W); b++) begin
                run(W'(a), W'(b), classify(W'(a), W'(b)));
            end
        end
        wait_idle();
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R3 all results delivered", exp_q.size(), 0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL R2 watchdog expired actual=%0h expected=%0h", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule